// File: doc/BRIEF.md
# Paged Serial Flash Erase Sequencer

This block erases a contiguous run of pages in a page-organised serial flash that is reached over SPI. A host hands it a start page index and a page count over a valid/ready request port. The block then walks the range one step at a time. At each step it chooses between a single-page erase and an eight-page block erase. It sends the matching four-byte command through a byte-wide SPI master port, then polls the flash status byte until the device reports ready. When the last step has been confirmed ready, it pulses `done`.

The flash addresses pages at a bit position that is not byte aligned: the page index is shifted left by a configurable amount (9, 10 or 11) before it is placed in the command. The shift and the idle gap between successive status polls are configuration inputs. Both are captured when a request is accepted. SPI bit timing belongs to the attached SPI master. That master accepts one byte per `tx_valid`/`tx_ready` handshake and reports the end of each byte exchange with a one-cycle `rx_valid` that carries the byte received.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `flash_sel`, `tx_valid` and `done` are 0.
- R2: A page erase frame is the four bytes 0x81, A[23:16], A[15:8], 0x00, sent in that order, where A is the current page index shifted left by the captured `cfg_page_shift` (9, 10 or 11).
- R3: A block erase frame uses opcode 0x50 with the same address bytes. It is chosen exactly when the low three bits of the current page index are zero and at least 8 pages remain. The index then advances by 8 and the remaining count drops by 8. After a page erase, both change by 1.
- R4: No page outside the request is erased: with fewer than 8 pages left, page erases are used even on an aligned index.
- R5: After each erase frame the block sends status frames of two bytes, 0xD7 then 0x00. The status is the byte received in the second exchange. The block keeps polling until bit 7 of the status (ready, active high) is 1, and only then moves to the next step.
- R6: `flash_sel` is 1 for the whole of each frame and falls in the cycle after the last byte's `rx_valid`. Between frames of one request it stays 0 for exactly 2 cycles, except between two status frames.
- R7: Between a status frame that reported busy and the next status frame, `flash_sel` stays 0 for exactly `cfg_poll_gap`+2 cycles, using the gap captured at acceptance.
- R8: `tx_data` and `tx_valid` hold while `tx_valid` is 1 and `tx_ready` is 0. A new byte is offered only after the previous exchange's `rx_valid`.
- R9: `done` is a one-cycle pulse, two cycles after the `rx_valid` that ends the final ready status frame. `req_ready` is 1 in that cycle.
- R10: A request with count 0 is accepted, gives `done` in the next cycle, and causes no SPI traffic.
- R11: `req_ready` is 0 while a request is in progress, and requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_page | input | PAGE_W | First page index to erase |
| req_count | input | CNT_W | Number of pages to erase |
| cfg_page_shift | input | 4 | Left shift of page index into the address (9, 10 or 11) |
| cfg_poll_gap | input | GAP_W | Idle cycles added between status polls |
| flash_sel | output | 1 | Chip select, active high |
| tx_valid | output | 1 | Byte offered to SPI master |
| tx_ready | input | 1 | SPI master takes the byte |
| tx_data | output | 8 | Byte to transmit |
| rx_valid | input | 1 | Byte exchange finished |
| rx_data | input | 8 | Byte received in that exchange |
| done | output | 1 | One-cycle pulse when the range is erased |

## Verification
The hardest behaviour to reach is a walk that mixes both erase sizes inside one request: unaligned pages first, then an aligned block, then a short tail, on an aligned index with fewer than eight pages left. Alongside that walk, busy status polls have to arrive at gap settings other than zero. The stimulus reaches this with start pages such as 5 with count 13, and 8 with count 7. The responding flash model reports busy for a set number of polls after every erase. Its handshake and reply latencies vary byte by byte, so hold and ordering rules are exercised under stalls. A request presented while busy, with different contents, is shown to leave the frame stream unchanged.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OPC_STATUS_RD   = 8'hD7;
    localparam int         BLOCK_PAGES     = 8;
    localparam int         READY_BIT       = 7;
    localparam int         ADDR_W          = 24;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ERASE_GO,
        SQ_ERASE_RUN,
        SQ_POLL_GO,
        SQ_POLL_RUN,
        SQ_GAP
    } seq_state_e;

    typedef enum logic [1:0] {
        FX_IDLE,
        FX_SEND,
        FX_WAIT
    } fx_state_e;

    typedef logic [3:0][7:0] frame_t;

    function automatic logic [ADDR_W-1:0] page_to_addr(input logic [ADDR_W-1:0] page_ext,
                                                       input logic [3:0] shamt);
        return page_ext << shamt;
    endfunction

    function automatic frame_t build_erase_frame(input logic [7:0] opcode,
                                                 input logic [ADDR_W-1:0] addr);
        frame_t f;
        f[0] = opcode;
        f[1] = addr[23:16];
        f[2] = addr[15:8];
        f[3] = 8'h00;
        return f;
    endfunction

    function automatic frame_t build_status_frame();
        frame_t f;
        f[0] = OPC_STATUS_RD;
        f[1] = 8'h00;
        f[2] = 8'h00;
        f[3] = 8'h00;
        return f;
    endfunction

endpackage

// File: rtl/erase_step_planner.sv
module erase_step_planner
    import flash_erase_pkg::*;
#(
    parameter int PAGE_W = 13,
    parameter int CNT_W  = 14
) (
    input  logic [PAGE_W-1:0] cur_page,
    input  logic [CNT_W-1:0]  remaining,
    input  logic [3:0]        page_shift,
    output logic              use_block,
    output logic [CNT_W-1:0]  step_len,
    output frame_t            erase_frame
);
    localparam logic [CNT_W-1:0] BLK_LEN  = CNT_W'(BLOCK_PAGES);
    localparam logic [CNT_W-1:0] PAGE_LEN = CNT_W'(1);

    logic [ADDR_W-1:0] flash_addr;

    always_comb begin
        use_block   = (cur_page[2:0] == 3'd0) && (remaining >= BLK_LEN);
        step_len    = use_block ? BLK_LEN : PAGE_LEN;
        flash_addr  = page_to_addr(ADDR_W'(cur_page), page_shift);
        erase_frame = build_erase_frame(use_block ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE,
                                        flash_addr);
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import flash_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_t     frame_in,
    input  logic [2:0] len_in,
    output logic       sel,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       frame_done,
    output logic [7:0] last_rx
);
    fx_state_e  st;
    frame_t     frame_q;
    logic [2:0] len_q;
    logic [1:0] idx;
    logic       last_byte;

    assign last_byte = ({1'b0, idx} == (len_q - 3'd1));
    assign tx_valid  = (st == FX_SEND);
    assign tx_data   = frame_q[idx];
    assign sel       = (st != FX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FX_IDLE;
            frame_q    <= '0;
            len_q      <= 3'd0;
            idx        <= 2'd0;
            frame_done <= 1'b0;
            last_rx    <= 8'h00;
        end else begin
            frame_done <= 1'b0;
            case (st)
                FX_IDLE: begin
                    if (start) begin
                        frame_q <= frame_in;
                        len_q   <= len_in;
                        idx     <= 2'd0;
                        st      <= FX_SEND;
                    end
                end
                FX_SEND: begin
                    if (tx_ready) st <= FX_WAIT;
                end
                FX_WAIT: begin
                    if (rx_valid) begin
                        if (last_byte) begin
                            st         <= FX_IDLE;
                            frame_done <= 1'b1;
                            last_rx    <= rx_data;
                        end else begin
                            idx <= idx + 2'd1;
                            st  <= FX_SEND;
                        end
                    end
                end
                default: st <= FX_IDLE;
            endcase
        end
    end

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_sel_drop_after_rx_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(sel) |-> $past(rx_valid));

    assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> !sel);

endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_val,
    output logic             gap_last
);
    logic [GAP_W-1:0] cnt;

    assign gap_last = (cnt == GAP_W'(1));

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= gap_val;
        else if (cnt != '0)   cnt <= cnt - GAP_W'(1);
    end

    assert_gap_load_idle_R7: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == '0));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int PAGE_W = 13,
    parameter int CNT_W  = 14,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [3:0]        cfg_page_shift,
    input  logic [GAP_W-1:0]  cfg_poll_gap,
    output logic              flash_sel,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              done
);
    seq_state_e        st;
    logic [PAGE_W-1:0] cur_page;
    logic [CNT_W-1:0]  remaining;
    logic [CNT_W-1:0]  step_q;
    logic [3:0]        shift_q;
    logic [GAP_W-1:0]  gap_q;
    logic              done_q;

    logic              plan_block;
    logic [CNT_W-1:0]  plan_step;
    frame_t            plan_frame;

    logic              fx_start;
    frame_t            fx_frame;
    logic [2:0]        fx_len;
    logic              fx_done;
    logic [7:0]        fx_last_rx;
    logic              dev_ready;
    logic              gap_load;
    logic              gap_last;

    erase_step_planner #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) planner_i (
        .cur_page   (cur_page),
        .remaining  (remaining),
        .page_shift (shift_q),
        .use_block  (plan_block),
        .step_len   (plan_step),
        .erase_frame(plan_frame)
    );

    always_comb begin
        fx_start = (st == SQ_ERASE_GO) || (st == SQ_POLL_GO);
        if (st == SQ_ERASE_GO) begin
            fx_frame = plan_frame;
            fx_len   = 3'd4;
        end else begin
            fx_frame = build_status_frame();
            fx_len   = 3'd2;
        end
    end

    spi_frame_engine engine_i (
        .clk       (clk),
        .rst       (rst),
        .start     (fx_start),
        .frame_in  (fx_frame),
        .len_in    (fx_len),
        .sel       (flash_sel),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .frame_done(fx_done),
        .last_rx   (fx_last_rx)
    );

    assign dev_ready = fx_last_rx[READY_BIT];
    assign gap_load  = (st == SQ_POLL_RUN) && fx_done && !dev_ready && (gap_q != '0);

    poll_gap_timer #(.GAP_W(GAP_W)) gap_i (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .gap_val (gap_q),
        .gap_last(gap_last)
    );

    assign req_ready = (st == SQ_IDLE);
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cur_page  <= '0;
            remaining <= '0;
            step_q    <= '0;
            shift_q   <= 4'd0;
            gap_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (req_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            cur_page  <= req_page;
                            remaining <= req_count;
                            shift_q   <= cfg_page_shift;
                            gap_q     <= cfg_poll_gap;
                            st        <= SQ_ERASE_GO;
                        end
                    end
                end
                SQ_ERASE_GO: begin
                    step_q <= plan_step;
                    st     <= SQ_ERASE_RUN;
                end
                SQ_ERASE_RUN: begin
                    if (fx_done) st <= SQ_POLL_GO;
                end
                SQ_POLL_GO: begin
                    st <= SQ_POLL_RUN;
                end
                SQ_POLL_RUN: begin
                    if (fx_done) begin
                        if (dev_ready) begin
                            cur_page  <= cur_page + PAGE_W'(step_q);
                            remaining <= remaining - step_q;
                            if (remaining == step_q) begin
                                done_q <= 1'b1;
                                st     <= SQ_IDLE;
                            end else begin
                                st <= SQ_ERASE_GO;
                            end
                        end else if (gap_q == '0) begin
                            st <= SQ_POLL_GO;
                        end else begin
                            st <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gap_last) st <= SQ_POLL_GO;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_block_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_ERASE_RUN && step_q == CNT_W'(BLOCK_PAGES)) |-> (cur_page[2:0] == 3'd0));

    assert_step_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_POLL_RUN) |-> (step_q <= remaining && remaining != '0));

    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        flash_sel |-> !req_ready);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !flash_sel));

endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
    localparam int PAGE_W = 13;
    localparam int CNT_W  = 14;
    localparam int GAP_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [PAGE_W-1:0] req_page = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic [3:0]        cfg_page_shift = 4'd9;
    logic [GAP_W-1:0]  cfg_poll_gap = '0;
    logic              flash_sel;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [7:0]        tx_data;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = 8'h00;
    logic              done;

    always #10 clk = ~clk;

    flash_erase_seq #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_count(req_count),
        .cfg_page_shift(cfg_page_shift), .cfg_poll_gap(cfg_poll_gap),
        .flash_sel(flash_sel), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .done(done)
    );

    int errors = 0;
    int checks = 0;
    int busy_cfg = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // Flash device model: byte handshake, delayed completion, busy countdown.
    int dev_idx = 0;
    int dev_busy = 0;
    int dev_bytes = 0;
    logic [7:0] dev_op = 8'h00;
    logic [7:0] dev_rsp = 8'h00;
    int dev_phase = 0;
    int dev_wait = 0;

    initial begin
        forever begin
            @(posedge clk); #3;
            tx_ready = 1'b0;
            rx_valid = 1'b0;
            if (rst) begin
                dev_phase = 0; dev_idx = 0; dev_wait = 0;
            end else begin
                if (!flash_sel) dev_idx = 0;
                if (dev_phase == 0) begin
                    if (tx_valid) begin
                        if (dev_wait < (dev_bytes % 3)) dev_wait++;
                        else begin
                            tx_ready = 1'b1;
                            dev_wait = 0;
                            if (dev_idx == 0) dev_op = tx_data;
                            dev_rsp = 8'h5A;
                            if (dev_op == 8'hD7 && dev_idx == 1) begin
                                if (dev_busy == 0) dev_rsp = 8'hAC;
                                else begin dev_rsp = 8'h7F; dev_busy--; end
                            end
                            if ((dev_op == 8'h81 || dev_op == 8'h50) && dev_idx == 3)
                                dev_busy = busy_cfg;
                            dev_idx++;
                            dev_phase = 1;
                        end
                    end
                end else begin
                    if (dev_wait < ((dev_bytes + 1) % 2)) dev_wait++;
                    else begin
                        rx_valid = 1'b1;
                        rx_data = dev_rsp;
                        dev_wait = 0;
                        dev_bytes++;
                        dev_phase = 0;
                    end
                end
            end
        end
    end

    // Reference model and monitor, sampled at the falling edge.
    bit m_active = 0;
    int m_page = 0, m_rem = 0, m_shift = 9, m_gap = 0, m_start = 0;
    int phase = 0, polls = 0, step = 1, exp_gap = 2, low_cnt = 0;
    bit first_frame = 1, done_due = 0, prev_sel = 0, outstanding = 0;
    bit pv_hold = 0;
    logic [7:0] pv_data = 8'h00;
    logic [7:0] fbytes[$];

    always @(negedge clk) begin
        if (!rst) begin
            if (done_due) begin
                chk(done == 1'b1, "R9", "done pulse", done, 1);
                chk(req_ready == 1'b1, "R9", "ready with done", req_ready, 1);
                done_due = 0;
            end else if (done) begin
                chk(1'b0, "R9", "unexpected done", done, 0);
            end
            if (m_active && req_ready) chk(1'b0, "R11", "ready while busy", req_ready, 0);
            if (req_valid && req_ready) begin
                if (req_count == 0) begin
                    done_due = 1;
                    chk(flash_sel == 1'b0, "R10", "no select on zero count", flash_sel, 0);
                end else begin
                    m_active = 1; m_page = int'(req_page); m_rem = int'(req_count);
                    m_start = m_page; m_shift = int'(cfg_page_shift);
                    m_gap = int'(cfg_poll_gap);
                    phase = 0; first_frame = 1;
                end
            end
            if (tx_valid && !flash_sel) chk(1'b0, "R6", "tx without select", flash_sel, 1);
            if (!m_active && flash_sel && !prev_sel)
                chk(1'b0, "R10", "traffic while idle", flash_sel, 0);
            if (pv_hold && (!tx_valid || tx_data != pv_data))
                chk(1'b0, "R8", "byte not held", tx_data, pv_data);
            if (tx_valid && tx_ready) begin
                if (outstanding) chk(1'b0, "R8", "byte before rx", 1, 0);
                outstanding = 1;
                fbytes.push_back(tx_data);
            end
            if (rx_valid) outstanding = 0;
            pv_hold = tx_valid && !tx_ready;
            pv_data = tx_data;

            if (flash_sel && !prev_sel) begin
                if (!first_frame)
                    chk(low_cnt == exp_gap, (exp_gap == 2) ? "R6" : "R7",
                        "deselect cycles", low_cnt, exp_gap);
                first_frame = 0;
            end
            if (flash_sel) low_cnt = 0; else low_cnt++;

            if (!flash_sel && prev_sel) begin
                if (phase == 0) begin
                    bit blk;
                    int addr;
                    string tg;
                    blk = (m_page % 8 == 0) && (m_rem >= 8);
                    addr = m_page << m_shift;
                    tg = blk ? "R3" : ((m_page % 8 == 0) ? "R4" : "R2");
                    chk(fbytes.size() == 4, tg, "erase frame length", fbytes.size(), 4);
                    if (fbytes.size() == 4) begin
                        chk(fbytes[0] == (blk ? 8'h50 : 8'h81), tg, "opcode", fbytes[0],
                            blk ? 8'h50 : 8'h81);
                        chk(fbytes[1] == addr[23:16], tg, "addr hi", fbytes[1], addr[23:16]);
                        chk(fbytes[2] == addr[15:8], tg, "addr mid", fbytes[2], addr[15:8]);
                        chk(fbytes[3] == 8'h00, tg, "tail byte", fbytes[3], 0);
                    end
                    step = blk ? 8 : 1;
                    phase = 1; polls = 0; exp_gap = 2;
                end else begin
                    chk(fbytes.size() == 2, "R5", "status frame length", fbytes.size(), 2);
                    if (fbytes.size() == 2) begin
                        chk(fbytes[0] == 8'hD7, "R5", "status opcode", fbytes[0], 8'hD7);
                        chk(fbytes[1] == 8'h00, "R5", "status filler", fbytes[1], 0);
                    end
                    polls++;
                    if (polls > busy_cfg) begin
                        m_page += step; m_rem -= step;
                        if (m_rem == 0) begin
                            m_active = 0; done_due = 1;
                        end else begin
                            phase = 0; exp_gap = 2;
                        end
                    end else begin
                        exp_gap = m_gap + 2;
                    end
                end
                fbytes.delete();
            end
            prev_sel = flash_sel;
        end
    end

    task automatic run_req(input int page, input int cnt, input int shamt, input int gap,
                           input int busy, input bit poke_busy);
        busy_cfg = busy;
        @(posedge clk); #3;
        while (!req_ready) begin @(posedge clk); #3; end
        req_page = PAGE_W'(page); req_count = CNT_W'(cnt);
        cfg_page_shift = 4'(shamt); cfg_poll_gap = GAP_W'(gap);
        req_valid = 1'b1;
        @(posedge clk); #3;
        req_valid = 1'b0;
        cfg_page_shift = 4'd0; cfg_poll_gap = GAP_W'(200);
        if (poke_busy) begin
            repeat (4) begin @(posedge clk); #3; end
            req_page = PAGE_W'(1); req_count = CNT_W'(40);   // R11: ignored while busy
            req_valid = 1'b1;
            repeat (5) begin @(posedge clk); #3; end
            req_valid = 1'b0;
        end
        repeat (3) begin @(posedge clk); #3; end
        while (m_active || done_due) begin @(posedge clk); #3; end
        repeat (3) begin @(posedge clk); #3; end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(flash_sel == 1'b0, "R1", "reset select", flash_sel, 0);
        chk(tx_valid == 1'b0, "R1", "reset tx_valid", tx_valid, 0);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        run_req(7, 0, 9, 0, 0, 0);            // R10 zero count
        run_req(3, 2, 9, 0, 1, 0);            // R2 page erases, R5 one busy poll
        run_req(0, 8, 10, 3, 2, 0);           // R3 single block, R7 gap 3
        run_req(5, 13, 11, 1, 1, 0);          // R3 mixed walk
        run_req(8, 7, 10, 0, 0, 0);           // R4 aligned short tail
        run_req(8184, 8, 11, 2, 1, 0);        // R2/R3 top address bytes
        run_req(2, 1, 9, 4, 6, 1);            // R11 ignored request while busy
        run_req(16, 9, 9, 0, 0, 0);           // R3 then R4
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule